// File: doc/BRIEF.md
# Indexed Context Propagation Unit

This unit holds seven stored instruction-prefix contexts so that one context word can be applied to several upcoming instructions without repeating the context in each of them. Each slot keeps a 32-bit context word and a 40-bit schedule shift register. The schedule bit at position 0 says whether that slot applies to the instruction that issues next.

An insert command names a slot (1 to 7), supplies a context word, and supplies a 20-bit schedule immediate. The context word replaces the slot's stored word. The schedule bits are appended to the slot's register at that slot's own fill offset, just after the last queued bit.

On every issue strobe, the unit ORs together the context words of all slots whose schedule bit 0 is set. It then shifts every schedule register right by one. The merged word is presented for one cycle with a valid flag. If the active slots carry different type tags, the unit raises an illegal flag instead.

Top module: `ctxprop_unit`

## Requirements
- R1: After reset, all schedules are empty and all fill offsets are zero. `ctx_o`, `ctx_valid_o`, `illegal_o` and `overflow_o` are all 0.
- R2: The append length of an insert is 20 minus the number of trailing zeros of `ins_sched_i`, and is 0 when the immediate is 0. The first appended bit, which applies to the earliest instruction, is `ins_sched_i[19]`. Each following appended bit comes from the next lower immediate bit.
- R3: Each slot appends at its own fill offset, and the offset then advances by the append length. A later insert into the same slot therefore continues after the earlier bits rather than overwriting them.
- R4: An insert replaces the stored context word of the selected slot, even when the append length is 0.
- R5: The cycle after an issue strobe, `ctx_o` is the OR of the stored words of all slots whose schedule bit 0 was set at the strobe. In that case `ctx_valid_o` is 1 when all their type tags (bits 3:0, where 0000 is RM, 0001 is swizzle and 0010 is remap) are equal. Every schedule then shifts right by one, and every nonzero offset drops by one.
- R6: If the active slots carry two or more different type tags, `illegal_o` is 1 for that cycle, `ctx_valid_o` is 0 and `ctx_o` is 0.
- R7: `ctx_valid_o`, `illegal_o` and `ctx_o` are 0 in any cycle that does not follow an issue strobe. They are also 0 after a strobe at which no slot was active.
- R8: An insert naming slot 0 changes no slot's context or schedule.
- R9: A fill offset that is already 0 stays 0 on a strobe. A following insert therefore appends from position 0.
- R10: When the offset plus the append length exceeds 40, `overflow_o` is 1 in the next cycle. The bits beyond position 39 are dropped, and the offset saturates at 40.
- R11: When an insert and a strobe arrive in the same cycle, the shift is applied first. The append then uses the decremented offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | 1 | Insert command strobe |
| ins_slot_i | input | 3 | Slot number 1..7; 0 selects nothing |
| ins_ctx_i | input | 32 | Context word, type tag in bits 3:0 |
| ins_sched_i | input | 20 | Schedule immediate |
| issue_i | input | 1 | Instruction issue strobe |
| ctx_o | output | 32 | Merged context word |
| ctx_valid_o | output | 1 | Merged context is usable |
| illegal_o | output | 1 | Type tag conflict among active slots |
| overflow_o | output | 1 | The previous insert overran the schedule |

## Verification
The bench builds the unit with its default parameters: seven slots, 40-bit schedules and a 20-bit immediate. With these values, two full-length appends plus a partial third are enough to reach the overflow boundary. Within a short run, random inserts also fill and drain every slot several times. Mixing tags 0 to 2 across slots brings tag conflicts, same-cycle insert and shift, and drained-slot saturation within reach of the random phase as well as the directed cases.

// File: rtl/ctxprop_pkg.sv
package ctxprop_pkg;
    localparam int CTX_W   = 32;
    localparam int TAG_W   = 4;
    localparam int SLOTS   = 7;
    localparam int SCHED_W = 40;
    localparam int IMM_W   = 20;

    typedef enum logic [TAG_W-1:0] {
        TAG_RM    = 4'd0,
        TAG_SWIZ  = 4'd1,
        TAG_REMAP = 4'd2
    } ctx_tag_e;
endpackage

// File: rtl/ctxprop_len.sv
module ctxprop_len #(
    parameter int IMM_W = ctxprop_pkg::IMM_W,
    localparam int CNT_W = $clog2(IMM_W + 1)
) (
    input  logic [IMM_W-1:0] imm_i,
    output logic [CNT_W-1:0] len_o
);
    logic [CNT_W-1:0] low_d;
    logic             any_d;

    always_comb begin
        low_d = '0;
        any_d = 1'b0;
        for (int k = IMM_W - 1; k >= 0; k--) begin
            if (imm_i[k]) begin
                low_d = CNT_W'(k);
                any_d = 1'b1;
            end
        end
        len_o = any_d ? (CNT_W'(IMM_W) - low_d) : '0;
    end
endmodule

// File: rtl/ctxprop_slot.sv
module ctxprop_slot #(
    parameter int SCHED_W = ctxprop_pkg::SCHED_W,
    parameter int IMM_W   = ctxprop_pkg::IMM_W,
    parameter int CTX_W   = ctxprop_pkg::CTX_W,
    localparam int CNT_W  = $clog2(IMM_W + 1),
    localparam int OFF_W  = $clog2(SCHED_W + 1),
    localparam int SUM_W  = OFF_W + 1,
    localparam int EXT_W  = SCHED_W + IMM_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             issue_i,
    input  logic             ins_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [CTX_W-1:0] ctx_i,
    output logic             active_o,
    output logic [CTX_W-1:0] ctx_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [SCHED_W-1:0] sched;
        logic [OFF_W-1:0]   off;
        logic [CTX_W-1:0]   ctx;
    } slot_st_t;

    slot_st_t           st_d, st_q;
    logic               ovf_d;
    logic [IMM_W-1:0]   rev_d;
    logic [IMM_W-1:0]   mask_d;
    logic [EXT_W-1:0]   ext_d;
    logic [OFF_W-1:0]   base_d;
    logic [SUM_W-1:0]   sum_d;

    always_comb begin
        st_d   = st_q;
        ovf_d  = 1'b0;
        rev_d  = '0;
        mask_d = '0;
        ext_d  = '0;
        sum_d  = '0;
        // shift first
        if (issue_i) begin
            st_d.sched = st_q.sched >> 1;
            if (st_q.off != '0) st_d.off = st_q.off - 1'b1;
        end
        base_d = st_d.off;
        // then append at the (possibly decremented) offset
        if (ins_i) begin
            st_d.ctx = ctx_i;
            for (int k = 0; k < IMM_W; k++) begin
                rev_d[k]  = imm_i[IMM_W-1-k];
                mask_d[k] = (CNT_W'(k) < len_i);
            end
            ext_d = EXT_W'(rev_d & mask_d) << base_d;
            st_d.sched = st_d.sched | ext_d[SCHED_W-1:0];
            sum_d = SUM_W'(base_d) + SUM_W'(len_i);
            if (sum_d > SUM_W'(SCHED_W)) begin
                ovf_d    = 1'b1;
                st_d.off = OFF_W'(SCHED_W);
            end else begin
                st_d.off = sum_d[OFF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = st_q.sched[0];
    assign ctx_o    = st_q.ctx;
    assign ovf_o    = ovf_d;

    AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.off <= OFF_W'(SCHED_W)); // R10
    AST_EMPTY_ABOVE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.sched >> st_q.off) == '0)); // R3
    AST_OFF_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !ins_i && st_q.off == '0) |=> (st_q.off == '0)); // R9
endmodule

// File: rtl/ctxprop_merge.sv
module ctxprop_merge #(
    parameter int SLOTS = ctxprop_pkg::SLOTS,
    parameter int CTX_W = ctxprop_pkg::CTX_W,
    parameter int TAG_W = ctxprop_pkg::TAG_W
) (
    input  logic [SLOTS-1:0]            active_i,
    input  logic [SLOTS-1:0][CTX_W-1:0] ctx_i,
    output logic [CTX_W-1:0]            merged_o,
    output logic                        any_o,
    output logic                        conflict_o
);
    logic [TAG_W-1:0] ref_d;
    logic             seen_d;

    always_comb begin
        merged_o   = '0;
        conflict_o = 1'b0;
        ref_d      = '0;
        seen_d     = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (active_i[s]) begin
                merged_o = merged_o | ctx_i[s];
                if (!seen_d) begin
                    ref_d  = ctx_i[s][TAG_W-1:0];
                    seen_d = 1'b1;
                end else if (ctx_i[s][TAG_W-1:0] != ref_d) begin
                    conflict_o = 1'b1;
                end
            end
        end
        any_o = seen_d;
    end
endmodule

// File: rtl/ctxprop_unit.sv
module ctxprop_unit
    import ctxprop_pkg::*;
#(
    parameter int N_SLOTS = SLOTS,
    parameter int SCH_W   = SCHED_W,
    parameter int IM_W    = IMM_W,
    parameter int CX_W    = CTX_W,
    localparam int IDX_W  = $clog2(N_SLOTS + 1),
    localparam int CNT_W  = $clog2(IM_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ins_valid_i,
    input  logic [IDX_W-1:0] ins_slot_i,
    input  logic [CX_W-1:0]  ins_ctx_i,
    input  logic [IM_W-1:0]  ins_sched_i,
    input  logic             issue_i,
    output logic [CX_W-1:0]  ctx_o,
    output logic             ctx_valid_o,
    output logic             illegal_o,
    output logic             overflow_o
);
    typedef struct packed {
        logic [CX_W-1:0] ctx;
        logic            valid;
        logic            illegal;
        logic            ovf;
    } out_st_t;

    out_st_t                        out_d, out_q;
    logic [CNT_W-1:0]               len_w;
    logic [N_SLOTS-1:0]             active_w;
    logic [N_SLOTS-1:0]             ovf_w;
    logic [N_SLOTS-1:0][CX_W-1:0]   sctx_w;
    logic [CX_W-1:0]                merged_w;
    logic                           any_w;
    logic                           conflict_w;

    ctxprop_len #(.IMM_W(IM_W)) len_i (
        .imm_i (ins_sched_i),
        .len_o (len_w)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic sel_w;
        assign sel_w = ins_valid_i && (ins_slot_i == IDX_W'(s + 1));
        ctxprop_slot #(.SCHED_W(SCH_W), .IMM_W(IM_W), .CTX_W(CX_W)) slot_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .issue_i  (issue_i),
            .ins_i    (sel_w),
            .len_i    (len_w),
            .imm_i    (ins_sched_i),
            .ctx_i    (ins_ctx_i),
            .active_o (active_w[s]),
            .ctx_o    (sctx_w[s]),
            .ovf_o    (ovf_w[s])
        );
    end

    ctxprop_merge #(.SLOTS(N_SLOTS), .CTX_W(CX_W), .TAG_W(TAG_W)) merge_i (
        .active_i   (active_w),
        .ctx_i      (sctx_w),
        .merged_o   (merged_w),
        .any_o      (any_w),
        .conflict_o (conflict_w)
    );

    always_comb begin
        out_d         = '0;
        out_d.ovf     = |ovf_w;
        if (issue_i) begin
            out_d.illegal = any_w && conflict_w;
            out_d.valid   = any_w && !conflict_w;
            out_d.ctx     = out_d.valid ? merged_w : '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign ctx_o       = out_q.ctx;
    assign ctx_valid_o = out_q.valid;
    assign illegal_o   = out_q.illegal;
    assign overflow_o  = out_q.ovf;

    AST_VALID_XOR_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ctx_valid_o && illegal_o)); // R6
    AST_QUIET_WITHOUT_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> (!ctx_valid_o && !illegal_o && ctx_o == '0)); // R7
    AST_ILLEGAL_ZERO_CTX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (ctx_o == '0)); // R6
    AST_OVF_NEEDS_INSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ins_valid_i |=> !overflow_o); // R10
endmodule

// File: tb/ctxprop_unit_tb.sv
module ctxprop_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_slot = '0;
    logic [31:0] ins_ctx = '0;
    logic [19:0] ins_sched = '0;
    logic        issue = 1'b0;
    logic [31:0] ctx_o;
    logic        ctx_valid_o, illegal_o, overflow_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ctxprop_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_valid), .ins_slot_i(ins_slot),
        .ins_ctx_i(ins_ctx), .ins_sched_i(ins_sched), .issue_i(issue),
        .ctx_o(ctx_o), .ctx_valid_o(ctx_valid_o), .illegal_o(illegal_o),
        .overflow_o(overflow_o)
    );

    // reference model
    bit [39:0] m_sched [7];
    int        m_off   [7];
    bit [31:0] m_ctx   [7];

    function automatic int app_len(bit [19:0] imm);
        for (int k = 0; k < 20; k++) if (imm[k]) return 20 - k;
        return 0;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: drive, advance model, compare registered outputs
    task automatic step(bit iv, bit [2:0] sl, bit [31:0] cx, bit [19:0] im, bit is, string req);
        bit [31:0] e_ctx; bit e_val, e_ill, e_ovf, any, conf; bit [3:0] rtag;
        @(negedge clk);
        ins_valid = iv; ins_slot = sl; ins_ctx = cx; ins_sched = im; issue = is;
        e_ctx = 0; any = 0; conf = 0; rtag = 0; e_ovf = 0;
        for (int s = 0; s < 7; s++) if (m_sched[s][0]) begin
            e_ctx |= m_ctx[s];
            if (!any) begin rtag = m_ctx[s][3:0]; any = 1; end
            else if (m_ctx[s][3:0] != rtag) conf = 1;
        end
        e_val = is && any && !conf;
        e_ill = is && any && conf;
        if (!e_val) e_ctx = 0;
        if (is) for (int s = 0; s < 7; s++) begin
            m_sched[s] = m_sched[s] >> 1;
            if (m_off[s] > 0) m_off[s]--;
        end
        if (iv && sl != 0) begin
            int s = int'(sl) - 1;
            int n = app_len(im);
            m_ctx[s] = cx;
            for (int k = 0; k < n; k++)
                if (m_off[s] + k < 40) m_sched[s][m_off[s] + k] = im[19 - k];
            if (m_off[s] + n > 40) begin e_ovf = 1; m_off[s] = 40; end
            else m_off[s] += n;
        end
        @(posedge clk); #1;
        check(req, "ctx_o", ctx_o, e_ctx);
        check(req, "ctx_valid_o", {31'b0, ctx_valid_o}, {31'b0, e_val});
        check(req, "illegal_o", {31'b0, illegal_o}, {31'b0, e_ill});
        check(req, "overflow_o", {31'b0, overflow_o}, {31'b0, e_ovf});
    endtask

    task automatic drain(int n, string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, req);
    endtask

    initial begin
        for (int s = 0; s < 7; s++) begin m_sched[s] = 0; m_off[s] = 0; m_ctx[s] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1", "ctx_o reset", ctx_o, 0);
        check("R1", "valid reset", {31'b0, ctx_valid_o}, 0);
        check("R1", "illegal reset", {31'b0, illegal_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 1, "R1");                       // empty schedules: nothing active
        // R2: pattern 1,0,1 (imm 101 in top bits, length 3)
        step(1, 1, 32'hAB00_0010, 20'b1010_0000_0000_0000_0000, 0, "R2");
        drain(4, "R2");
        // R3: two appends into one slot, continue after the first
        step(1, 2, 32'h0000_1000, 20'h80000, 0, "R3");
        step(1, 2, 32'h0000_2000, 20'hC0000, 0, "R3");
        drain(4, "R3");
        // R4: zero-length insert still replaces context
        step(1, 3, 32'h5500_0000, 20'h80000, 0, "R4");
        step(1, 3, 32'h00AA_0000, 20'h00000, 0, "R4");
        drain(2, "R4");
        // R5: merge of same-tag slots
        step(1, 4, 32'h0100_0001, 20'h80000, 0, "R5");
        step(1, 5, 32'h0200_0001, 20'h80000, 0, "R5");
        drain(2, "R5");
        // R6: tag conflict
        step(1, 6, 32'h0000_0100, 20'h80000, 0, "R6");
        step(1, 7, 32'h0000_0202, 20'h80000, 0, "R6");
        drain(2, "R6");
        // R7: no issue, outputs quiet while slot is loaded
        step(1, 1, 32'h0000_0F00, 20'hFFFFF, 0, "R7");
        step(0, 0, 0, 0, 0, "R7");
        drain(21, "R7");
        // R8: slot 0 ignored
        step(1, 0, 32'hFFFF_FFF0, 20'hFFFFF, 0, "R8");
        drain(2, "R8");
        // R9: empty offsets saturate, then append from 0
        drain(3, "R9");
        step(1, 2, 32'h0000_0030, 20'h80000, 0, "R9");
        drain(2, "R9");
        // R10: overflow, excess dropped
        step(1, 3, 32'h0000_0700, 20'h00001, 0, "R10");
        step(1, 3, 32'h0000_0700, 20'h00001, 0, "R10");
        step(1, 3, 32'h0000_0700, 20'h00001, 0, "R10");
        drain(42, "R10");
        // R11: insert together with issue
        step(1, 4, 32'h0000_0040, 20'hC0000, 0, "R11");
        step(1, 4, 32'h0000_0050, 20'h80000, 1, "R11");
        drain(3, "R11");
        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            bit iv = ($urandom % 3) == 0;
            bit [2:0] sl = 3'($urandom % 8);
            bit [31:0] cx = {$urandom} & 32'hFFFF_FFF0;
            bit [19:0] im = 20'($urandom);
            cx[3:0] = (($urandom % 4) == 0) ? 4'(($urandom % 3)) : 4'(sl % 2);
            if (($urandom % 4) == 0) im = im & 20'hFFC00;
            step(iv, sl, cx, im, ($urandom % 4) != 0, "R5");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule